// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Flags

This block sits between a small register port and a serial byte engine. It holds one queue of outgoing bytes and one queue of incoming bytes, each sixteen bytes deep. Software fills the outgoing queue and drains the incoming one through a single data register. The engine pops outgoing bytes and pushes received bytes through a simple strobe interface.

Each queue has a programmable threshold. When the queue crosses its threshold, a sticky status flag is raised. A third flag reports that the engine finished a byte while the outgoing queue was empty. A mask register routes the flags to one interrupt line. A control register empties either queue on its own and sets both thresholds. The bus protocol and bit timing are outside this block.

Register select values on `bus_addr`:
- 0: data port. A write pushes to the outgoing queue. A read pops the incoming queue.
- 1: control.
- 2: flags.
- 3: interrupt mask.
- 4: outgoing count.
- 5: incoming count.

Top module: `fifo_pair_trig`

## Requirements
- R1: While reset is held, the flags read 0. On the first cycle after reset both counts read 0, `irq` is 0, `eng_tx_valid` is 0 and `eng_rx_ready` is 1.
- R2: Bytes written to the data port leave on `eng_tx_data` in write order. The head byte is shown whenever `eng_tx_valid` is 1, and an `eng_tx_pop` advances the queue. The outgoing count (select 4) gives the occupancy, 0 to 16.
- R3: A data-port write while the outgoing queue holds 16 bytes is dropped. Neither the count nor the queued contents change.
- R4: A read of the data port returns the oldest incoming byte and removes it. When the incoming queue is empty, the read returns 0 and the count stays 0.
- R5: Writing the control register with bit 0 set empties the outgoing queue, and with bit 1 set empties the incoming queue. The count reads 0 on the next cycle. The other queue is untouched.
- R6: Incoming-threshold flag, flag bit 1. The threshold field is control bits 7:4, value t. The flag is raised while the incoming count is t+1 or more.
- R7: Outgoing-threshold flag, flag bit 0. The code is control bits 3:2. The flag is raised while the outgoing count is at most the level the code selects: code 0 selects 8, code 1 selects 4, code 2 selects 2 and code 3 selects 0.
- R8: Flag bit 2 is raised when `eng_tx_sent` pulses while the outgoing queue is empty. The same pulse with bytes queued does not raise it.
- R9: Flags are sticky. A flags-register write with 0 in a bit position clears that flag, and a 1 in that position leaves it. A flag whose condition still holds during the clearing write stays set.
- R10: `irq` is high when any flag is set and its bit (0, 1 or 2) in the mask register (select 3) is 1. The mask register reads back as written.
- R11: `eng_rx_ready` drops when the incoming queue holds 16 bytes. An `eng_rx_push` at that point is dropped and the count stays 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the incoming queue at select 0) |
| bus_addr | input | AW | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from select |
| eng_tx_pop | input | 1 | Engine takes the head outgoing byte |
| eng_tx_data | output | DW | Head outgoing byte |
| eng_tx_valid | output | 1 | Outgoing queue not empty |
| eng_tx_sent | input | 1 | Engine finished shifting a byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | DW | Received byte |
| eng_rx_ready | output | 1 | Incoming queue has space |
| irq | output | 1 | Masked OR of the flags |

## Verification
Queue counts and the engine-side outputs change on the clock edge that takes a push, pop or clear. Data-port read values are combinational in the same cycle as the read strobe. A flag reflects its condition one edge after the count that drives it, and the bench exploits this: it writes 0 to the flags register one cycle after each push, so that the flag then equals the threshold condition at the current count. It reads the result at the following falling edge. Every drive happens at a falling edge and every sample just after one, so each result is taken one full register stage after its cause.

// File: rtl/fq_pkg.sv
package fq_pkg;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_CTRL  = 3'd1,
        SEL_FLAGS = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_TXCNT = 3'd4,
        SEL_RXCNT = 3'd5
    } reg_sel_e;

    localparam int NFLAGS  = 3;
    localparam int FL_TXT  = 0;
    localparam int FL_RXT  = 1;
    localparam int FL_TXE  = 2;

    typedef struct packed {
        logic [3:0] rx_trig;
        logic [1:0] tx_code;
    } trig_cfg_t;

    function automatic int unsigned tx_level(input logic [1:0] code, input int unsigned depth);
        case (code)
            2'd0:    return depth / 2;
            2'd1:    return depth / 4;
            2'd2:    return depth / 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr) |=> (count == CW'(DEPTH)));

    // R5
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

endmodule

// File: rtl/fifo_flags.sv
module fifo_flags
    import fq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     tx_count,
    input  logic [CW-1:0]     rx_count,
    input  trig_cfg_t         cfg,
    input  logic              tx_sent,
    input  logic              clr_wr,
    input  logic [NFLAGS-1:0] keep_mask,
    output logic [NFLAGS-1:0] flags
);
    logic [NFLAGS-1:0] cond;
    logic [CW-1:0]     rx_lvl;
    int unsigned       tx_lvl;

    always_comb begin
        rx_lvl       = CW'(cfg.rx_trig) + CW'(1);
        tx_lvl       = tx_level(cfg.tx_code, DEPTH);
        cond[FL_TXT] = (32'(tx_count) <= tx_lvl);
        cond[FL_RXT] = (rx_count >= rx_lvl);
        cond[FL_TXE] = tx_sent && (tx_count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (clr_wr ? (flags & keep_mask) : flags) | cond;
    end

    // R6
    rx_trig_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count >= rx_lvl) |=> flags[FL_RXT]);

    // R9
    rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !keep_mask[FL_RXT] && !(rx_count >= rx_lvl)) |=> !flags[FL_RXT]);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[FL_TXE] && !clr_wr) |=> flags[FL_TXE]);

endmodule

// File: rtl/fifo_pair_trig.sv
module fifo_pair_trig
    import fq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_data,
    output logic          eng_tx_valid,
    input  logic          eng_tx_sent,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data,
    output logic          eng_rx_ready,
    output logic          irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0]     tx_count, rx_count;
    logic [DW-1:0]     rx_head;
    logic              sel_data, sel_ctrl, sel_flags, sel_mask;
    logic              tx_clr, rx_clr, tx_push, rx_pop;
    trig_cfg_t         cfg_q;
    logic [NFLAGS-1:0] mask_q, flags;

    assign sel_data  = (bus_addr == AW'(SEL_DATA));
    assign sel_ctrl  = (bus_addr == AW'(SEL_CTRL));
    assign sel_flags = (bus_addr == AW'(SEL_FLAGS));
    assign sel_mask  = (bus_addr == AW'(SEL_MASK));

    assign tx_clr  = bus_wr && sel_ctrl && bus_wdata[0];
    assign rx_clr  = bus_wr && sel_ctrl && bus_wdata[1];
    assign tx_push = bus_wr && sel_data;
    assign rx_pop  = bus_rd && sel_data;

    byte_fifo #(.DW(DW), .DEPTH(DEPTH)) tx_q (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(tx_push), .wdata(bus_wdata),
        .pop(eng_tx_pop), .rdata(eng_tx_data), .count(tx_count)
    );

    byte_fifo #(.DW(DW), .DEPTH(DEPTH)) rx_q (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(rx_pop), .rdata(rx_head), .count(rx_count)
    );

    fifo_flags #(.DEPTH(DEPTH)) flag_u (
        .clk(clk), .rst(rst),
        .tx_count(tx_count), .rx_count(rx_count),
        .cfg(cfg_q), .tx_sent(eng_tx_sent),
        .clr_wr(bus_wr && sel_flags),
        .keep_mask(bus_wdata[NFLAGS-1:0]),
        .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            if (sel_ctrl) begin
                cfg_q.rx_trig <= bus_wdata[7:4];
                cfg_q.tx_code <= bus_wdata[3:2];
            end
            if (sel_mask) mask_q <= bus_wdata[NFLAGS-1:0];
        end
    end

    assign eng_tx_valid = (tx_count != '0);
    assign eng_rx_ready = (rx_count != CW'(DEPTH));
    assign irq          = |(flags & mask_q);

    always_comb begin
        case (bus_addr)
            AW'(SEL_DATA):  bus_rdata = (rx_count == '0) ? '0 : rx_head;
            AW'(SEL_CTRL):  bus_rdata = DW'({cfg_q.rx_trig, cfg_q.tx_code, 2'b00});
            AW'(SEL_FLAGS): bus_rdata = DW'(flags);
            AW'(SEL_MASK):  bus_rdata = DW'(mask_q);
            AW'(SEL_TXCNT): bus_rdata = DW'(tx_count);
            AW'(SEL_RXCNT): bus_rdata = DW'(rx_count);
            default:        bus_rdata = '0;
        endcase
    end

    // R4
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_count == '0) |-> (bus_rdata == '0));

    // R5
    tx_clr_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_clr && !rx_clr && !eng_rx_push && !rx_pop) |=> (rx_count == $past(rx_count)));

    // R11
    rx_ready_full_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count == CW'(DEPTH)) |-> !eng_rx_ready);

endmodule

// File: tb/fifo_pair_trig_tb_top.sv
module fifo_pair_trig_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       eng_tx_pop = 0, eng_tx_sent = 0, eng_rx_push = 0;
    logic [7:0] eng_tx_data, eng_rx_data = 0;
    logic       eng_tx_valid, eng_rx_ready, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fifo_pair_trig dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
        .eng_tx_sent(eng_tx_sent), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_rx_ready(eng_rx_ready), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic eng_push(input logic [7:0] d);
        @(negedge clk);
        eng_rx_push = 1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 0;
    endtask

    task automatic eng_pop(output logic [7:0] d);
        @(negedge clk);
        #1 d = eng_tx_data;
        eng_tx_pop = 1;
        @(negedge clk);
        eng_tx_pop = 0;
    endtask

    task automatic pulse_sent();
        @(negedge clk);
        eng_tx_sent = 1;
        @(negedge clk);
        eng_tx_sent = 0;
    endtask

    function automatic int lvl_of(input int code);
        case (code)
            0: return 8;
            1: return 4;
            2: return 2;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        peek(3'd2, v);
        check("R1 flags in reset", v, 0);
        rst = 0;
        @(negedge clk);
        peek(3'd4, v); check("R1 tx count", v, 0);
        peek(3'd5, v); check("R1 rx count", v, 0);
        check("R1 irq", irq, 0);
        check("R1 tx_valid", eng_tx_valid, 0);
        check("R1 rx_ready", eng_rx_ready, 1);

        // R2 order and count, R3 overfull write dropped
        for (int i = 0; i < 16; i++) wr(3'd0, 8'(i * 7 + 3));
        peek(3'd4, v); check("R2 tx count 16", v, 16);
        check("R2 tx_valid", eng_tx_valid, 1);
        for (int i = 0; i < 16; i++) begin
            eng_pop(v); check("R2 tx order", v, (i * 7 + 3) & 8'hff);
        end
        peek(3'd4, v); check("R2 tx count 0", v, 0);
        for (int i = 0; i < 17; i++) wr(3'd0, 8'(255 - i * 11));
        peek(3'd4, v); check("R3 count stays 16", v, 16);
        for (int i = 0; i < 16; i++) begin
            eng_pop(v); check("R3 contents intact", v, (255 - i * 11) & 8'hff);
        end

        // R11 and R4
        for (int i = 0; i < 17; i++) eng_push(8'(i * 13 + 1));
        check("R11 rx_ready low when full", eng_rx_ready, 0);
        peek(3'd5, v); check("R11 rx count 16", v, 16);
        for (int i = 0; i < 16; i++) begin
            rd(3'd0, v); check("R4 rx order", v, (i * 13 + 1) & 8'hff);
        end
        rd(3'd0, v); check("R4 empty read zero", v, 0);
        peek(3'd5, v); check("R4 count stays 0", v, 0);

        // R5 separate clears
        for (int i = 0; i < 5; i++) wr(3'd0, 8'(i));
        for (int i = 0; i < 3; i++) eng_push(8'(i));
        wr(3'd1, 8'h01);
        peek(3'd4, v); check("R5 tx cleared", v, 0);
        peek(3'd5, v); check("R5 rx untouched", v, 3);
        wr(3'd1, 8'h02);
        peek(3'd5, v); check("R5 rx cleared", v, 0);
        peek(3'd4, v); check("R5 tx still 0", v, 0);

        // R6 sweep over every threshold and count
        for (int t = 0; t < 16; t++) begin
            wr(3'd1, 8'((t << 4) | 2));
            for (int c = 0; c <= 16; c++) begin
                wr(3'd2, 8'h00);
                peek(3'd2, v);
                check("R6 rx trigger", v[1], (c >= t + 1) ? 1 : 0);
                eng_push(8'(c));
            end
        end
        wr(3'd1, 8'h02);

        // R7 sweep over codes and counts
        for (int code = 0; code < 4; code++) begin
            wr(3'd1, 8'((code << 2) | 1));
            for (int c = 0; c <= 16; c++) begin
                wr(3'd2, 8'h00);
                peek(3'd2, v);
                check("R7 tx trigger", v[0], (c <= lvl_of(code)) ? 1 : 0);
                wr(3'd0, 8'(c));
            end
        end

        // R8 transmit end, R9 stickiness
        wr(3'd1, 8'h01);
        wr(3'd2, 8'h00);
        peek(3'd2, v); check("R8 no end before pulse", v[2], 0);
        pulse_sent();
        peek(3'd2, v); check("R8 end flag on empty", v[2], 1);
        repeat (3) @(negedge clk);
        peek(3'd2, v); check("R9 flag held", v[2], 1);
        wr(3'd2, 8'h04);
        peek(3'd2, v); check("R9 write one keeps", v[2], 1);
        wr(3'd2, 8'h00);
        peek(3'd2, v); check("R9 write zero clears", v[2], 0);
        wr(3'd0, 8'h55);
        wr(3'd2, 8'h00);
        pulse_sent();
        peek(3'd2, v); check("R8 no end with bytes queued", v[2], 0);
        wr(3'd1, 8'h02);
        eng_push(8'h77);
        wr(3'd2, 8'h00);
        peek(3'd2, v); check("R9 condition re-sets", v[1], 1);

        // R10 interrupt masking
        wr(3'd3, 8'h00);
        check("R10 irq masked", irq, 0);
        wr(3'd3, 8'h02);
        check("R10 irq on rx flag", irq, 1);
        peek(3'd3, v); check("R10 mask readback", v, 2);
        wr(3'd3, 8'h04);
        check("R10 irq end flag clear", irq, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule